// File: doc/BRIEF.md
# Memory Bank Power Gating Controller

This block decides which banks of an on-chip memory system receive power. It serves a parameterised set of SRAM banks (eight by default) and flash banks (two by default). Software programs three control words through a simple write/read port: a per-bank mask that marks SRAM banks to be dropped during deep sleep, a per-bank hard-off mask for SRAM, and a per-bank hard-off mask for flash. The block drives one power-enable level per bank towards the analog switches, which sit outside the block.

Each bank also carries a "contents valid" flag. It models whether the data held in the bank survived. The flag falls whenever the bank loses power, whatever the cause. It rises again only when the owner of the bank pulses that bank's reinitialise strobe while the bank is powered.

The block also watches a memory access bus. Bank address ranges are a base address plus the bank index times a parameterised bank size. An access that lands in a bank whose hard-off bit is set produces a one-cycle fault pulse in the same cycle. A bank dropped only because of deep sleep produces no fault; it just loses its contents.

Top module: `bank_pwr_ctrl`

## Requirements
- R1: After reset all three control words read zero, every bank power enable is 1, every valid flag is 0 and the fault output is 0.
- R2: The control words sit at byte offset 0x140 (SRAM sleep-drop mask), 0x144 (SRAM hard-off mask) and 0x148 (flash hard-off mask). Bit i of an SRAM word belongs to SRAM bank i, and bits 0 and 1 of the flash word belong to flash banks 0 and 1. A write takes effect at the next clock edge. The read data is a combinational function of the read offset.
- R3: Bits above the bank count read as zero: bits 31:8 of the SRAM words and bits 31:2 of the flash word. Any other offset reads zero, and a write to it changes nothing.
- R4: The power enable of SRAM bank i is 1 exactly when its hard-off bit is 0 and it is not the case that deep_sleep is 1 while its sleep-drop bit is 1. The power enable of a flash bank is the inverse of its hard-off bit, and deep sleep has no effect on it.
- R5: When acc_valid is 1 and acc_addr falls in [base + i*size, base + (i+1)*size) of a bank whose hard-off bit is set, bank_fault is 1 in that same cycle.
- R6: bank_fault is 0 when acc_valid is 0, when the address lies outside every bank range, when the addressed bank's hard-off bit is clear, and when the bank is unpowered only because of deep sleep.
- R7: A reinitialise strobe on a powered bank sets its valid flag at the next clock edge.
- R8: A bank whose power enable is 0 in a cycle has its valid flag 0 after the next clock edge. The flag stays 0 after power returns until a new strobe arrives.
- R9: An SRAM bank with its sleep-drop bit clear keeps power and its valid flag throughout deep sleep.
- R10: A reinitialise strobe on an unpowered bank is ignored, and its valid flag stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control port |
| reg_addr | input | 12 | Byte offset for the read and the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| deep_sleep | input | 1 | High while the system is in deep sleep |
| sram_init | input | 8 | Per-bank SRAM reinitialise strobes |
| flash_init | input | 2 | Per-bank flash reinitialise strobes |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Byte address of the access |
| sram_pwr_en | output | 8 | SRAM bank power enables |
| flash_pwr_en | output | 2 | Flash bank power enables |
| sram_valid | output | 8 | SRAM bank contents-valid flags |
| flash_valid | output | 2 | Flash bank contents-valid flags |
| bank_fault | output | 1 | One-cycle pulse on an access to a hard-off bank |

## Verification
The bench keeps the default eight SRAM and two flash banks but shrinks the bank sizes to 256 bytes for SRAM and 4 KiB for flash. It also moves the flash base off zero, so the address just below each window exists and can be probed. With these values, a single sweep reaches the first and last byte of every bank, the byte just past the final bank, and the byte just below each base. A randomised phase mixes register writes, sleep entry and exit, strobes and accesses, and a behavioural model predicts every output on every cycle.

// File: rtl/bank_pwr_pkg.sv
package bank_pwr_pkg;
    localparam int unsigned REG_DW        = 32;
    localparam int unsigned OFF_SLEEP_DROP = 32'h140;
    localparam int unsigned OFF_SRAM_OFF   = 32'h144;
    localparam int unsigned OFF_FLASH_OFF  = 32'h148;
endpackage

// File: rtl/bpc_ctrl_regs.sv
module bpc_ctrl_regs
    import bank_pwr_pkg::*;
#(
    parameter int unsigned NUM_SRAM  = 8,
    parameter int unsigned NUM_FLASH = 2,
    parameter int unsigned REG_AW    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [REG_DW-1:0]    reg_wdata,
    output logic [REG_DW-1:0]    reg_rdata,
    output logic [NUM_SRAM-1:0]  slp_mask_o,
    output logic [NUM_SRAM-1:0]  sram_off_o,
    output logic [NUM_FLASH-1:0] flash_off_o
);
    localparam logic [REG_AW-1:0] A_SLP  = REG_AW'(OFF_SLEEP_DROP);
    localparam logic [REG_AW-1:0] A_SOFF = REG_AW'(OFF_SRAM_OFF);
    localparam logic [REG_AW-1:0] A_FOFF = REG_AW'(OFF_FLASH_OFF);

    typedef struct packed {
        logic [NUM_SRAM-1:0]  slp;
        logic [NUM_SRAM-1:0]  soff;
        logic [NUM_FLASH-1:0] foff;
    } ctl_t;

    ctl_t              ctl_d, ctl_q;
    logic [REG_DW-1:0] rd_d;
    logic              unused_wdata;

    assign unused_wdata = ^reg_wdata;

    always_comb begin
        ctl_d = ctl_q;
        rd_d  = '0;
        if (reg_wr) begin
            if (reg_addr == A_SLP)  ctl_d.slp  = reg_wdata[NUM_SRAM-1:0];
            if (reg_addr == A_SOFF) ctl_d.soff = reg_wdata[NUM_SRAM-1:0];
            if (reg_addr == A_FOFF) ctl_d.foff = reg_wdata[NUM_FLASH-1:0];
        end
        if (reg_addr == A_SLP)  rd_d[NUM_SRAM-1:0]  = ctl_q.slp;
        if (reg_addr == A_SOFF) rd_d[NUM_SRAM-1:0]  = ctl_q.soff;
        if (reg_addr == A_FOFF) rd_d[NUM_FLASH-1:0] = ctl_q.foff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign reg_rdata   = rd_d;
    assign slp_mask_o  = ctl_q.slp;
    assign sram_off_o  = ctl_q.soff;
    assign flash_off_o = ctl_q.foff;

    assert_sleep_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_SLP) |=> (slp_mask_o == $past(reg_wdata[NUM_SRAM-1:0])));

    assert_flash_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_FOFF) |=> (flash_off_o == $past(reg_wdata[NUM_FLASH-1:0])));

    assert_rd_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(reg_rdata) <= NUM_SRAM));

    assert_no_write_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> ($stable(sram_off_o) && $stable(flash_off_o) && $stable(slp_mask_o)));
endmodule

// File: rtl/bpc_valid_track.sv
module bpc_valid_track #(
    parameter int unsigned NUM_BANKS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] pwr_en,
    input  logic [NUM_BANKS-1:0] init,
    output logic [NUM_BANKS-1:0] valid
);
    logic [NUM_BANKS-1:0] valid_d, valid_q;

    always_comb begin
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (!pwr_en[i]) valid_d[i] = 1'b0;
            else            valid_d[i] = valid_q[i] | init[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    assign valid = valid_q;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_chk
        assert_loss_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !pwr_en[g] |=> !valid[g]);
        assert_set_needs_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(valid[g]) |-> $past(init[g] && pwr_en[g]));
    end
endmodule

// File: rtl/bpc_addr_fault.sv
module bpc_addr_fault #(
    parameter int unsigned NUM_BANKS  = 8,
    parameter int unsigned BANK_BYTES = 8192,
    parameter logic [31:0] BASE       = 32'h1000_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic [31:0]          acc_addr,
    input  logic [NUM_BANKS-1:0] off_mask,
    output logic                 fault
);
    localparam int unsigned SPAN_LOG = $clog2(BANK_BYTES);
    localparam logic [63:0] SPAN     = 64'(NUM_BANKS) * 64'(BANK_BYTES);

    logic [31:0]          offset;
    logic                 in_range;
    logic [NUM_BANKS-1:0] hit;

    assign offset   = acc_addr - BASE;
    assign in_range = (acc_addr >= BASE) && ({32'd0, offset} < SPAN);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_hit
        assign hit[g] = in_range && ((offset >> SPAN_LOG) == 32'(g));
    end

    assign fault = acc_valid && |(hit & off_mask);

    assert_single_bank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    assert_fault_needs_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (acc_valid && off_mask != '0));
endmodule

// File: rtl/bank_pwr_ctrl.sv
module bank_pwr_ctrl
    import bank_pwr_pkg::*;
#(
    parameter int unsigned NUM_SRAM    = 8,
    parameter int unsigned NUM_FLASH   = 2,
    parameter int unsigned REG_AW      = 12,
    parameter int unsigned SRAM_BYTES  = 8192,
    parameter int unsigned FLASH_BYTES = 262144,
    parameter logic [31:0] SRAM_BASE   = 32'h1000_0000,
    parameter logic [31:0] FLASH_BASE  = 32'h0000_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [REG_DW-1:0]    reg_wdata,
    output logic [REG_DW-1:0]    reg_rdata,
    input  logic                 deep_sleep,
    input  logic [NUM_SRAM-1:0]  sram_init,
    input  logic [NUM_FLASH-1:0] flash_init,
    input  logic                 acc_valid,
    input  logic [31:0]          acc_addr,
    output logic [NUM_SRAM-1:0]  sram_pwr_en,
    output logic [NUM_FLASH-1:0] flash_pwr_en,
    output logic [NUM_SRAM-1:0]  sram_valid,
    output logic [NUM_FLASH-1:0] flash_valid,
    output logic                 bank_fault
);
    logic [NUM_SRAM-1:0]  slp_mask, sram_off;
    logic [NUM_FLASH-1:0] flash_off;
    logic                 sram_fault, flash_fault;

    bpc_ctrl_regs #(
        .NUM_SRAM(NUM_SRAM), .NUM_FLASH(NUM_FLASH), .REG_AW(REG_AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .slp_mask_o(slp_mask), .sram_off_o(sram_off), .flash_off_o(flash_off)
    );

    assign sram_pwr_en  = ~sram_off & ~({NUM_SRAM{deep_sleep}} & slp_mask);
    assign flash_pwr_en = ~flash_off;

    bpc_valid_track #(.NUM_BANKS(NUM_SRAM)) u_sram_valid (
        .clk(clk), .rst_n(rst_n), .pwr_en(sram_pwr_en), .init(sram_init), .valid(sram_valid)
    );

    bpc_valid_track #(.NUM_BANKS(NUM_FLASH)) u_flash_valid (
        .clk(clk), .rst_n(rst_n), .pwr_en(flash_pwr_en), .init(flash_init), .valid(flash_valid)
    );

    bpc_addr_fault #(
        .NUM_BANKS(NUM_SRAM), .BANK_BYTES(SRAM_BYTES), .BASE(SRAM_BASE)
    ) u_sram_fault (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .off_mask(sram_off), .fault(sram_fault)
    );

    bpc_addr_fault #(
        .NUM_BANKS(NUM_FLASH), .BANK_BYTES(FLASH_BYTES), .BASE(FLASH_BASE)
    ) u_flash_fault (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .off_mask(flash_off), .fault(flash_fault)
    );

    assign bank_fault = sram_fault | flash_fault;

    assert_awake_power_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !deep_sleep |-> ((sram_pwr_en ^ ~sram_off) == '0));

    assert_fault_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bank_fault |-> acc_valid);
endmodule

// File: tb/bank_pwr_ctrl_tb_top.sv
`timescale 1ns/1ps
module bank_pwr_ctrl_tb_top;
    localparam int unsigned NS = 8;
    localparam int unsigned NF = 2;
    localparam longint unsigned SB = 64'h2000_0000;
    localparam longint unsigned SS = 256;
    localparam longint unsigned FB = 64'h0001_0000;
    localparam longint unsigned FS = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        deep_sleep = 1'b0;
    logic [7:0]  sram_init = '0;
    logic [1:0]  flash_init = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [7:0]  sram_pwr_en, sram_valid;
    logic [1:0]  flash_pwr_en, flash_valid;
    logic        bank_fault;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    bit [7:0] m_slp = 0, m_sdis = 0, m_sval = 0;
    bit [1:0] m_fdis = 0, m_fval = 0;

    always #4 clk = ~clk;

    bank_pwr_ctrl #(
        .NUM_SRAM(NS), .NUM_FLASH(NF), .REG_AW(12),
        .SRAM_BYTES(SS), .FLASH_BYTES(FS),
        .SRAM_BASE(32'(SB)), .FLASH_BASE(32'(FB))
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .deep_sleep(deep_sleep),
        .sram_init(sram_init), .flash_init(flash_init), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .sram_pwr_en(sram_pwr_en), .flash_pwr_en(flash_pwr_en),
        .sram_valid(sram_valid), .flash_valid(flash_valid), .bank_fault(bank_fault)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit [31:0] exp_rd();
        case (reg_addr)
            12'h140: return {24'd0, m_slp};
            12'h144: return {24'd0, m_sdis};
            12'h148: return {30'd0, m_fdis};
            default: return 32'd0;
        endcase
    endfunction

    function automatic bit exp_fault();
        longint unsigned a = longint'(acc_addr);
        if (!acc_valid) return 1'b0;
        if (a >= SB && a < SB + NS * SS) return m_sdis[(a - SB) / SS];
        if (a >= FB && a < FB + NF * FS) return m_fdis[(a - FB) / FS];
        return 1'b0;
    endfunction

    // Called just after a falling edge with inputs already set.
    task automatic cyc(input string tag);
        bit [7:0] e_spwr;
        bit [1:0] e_fpwr;
        #2;
        e_spwr = ~m_sdis & ~(deep_sleep ? m_slp : 8'h00);
        e_fpwr = ~m_fdis;
        check(tag, "reg_rdata", reg_rdata, exp_rd());
        check(tag, "sram_pwr_en", 32'(sram_pwr_en), 32'(e_spwr));
        check(tag, "flash_pwr_en", 32'(flash_pwr_en), 32'(e_fpwr));
        check(tag, "sram_valid", 32'(sram_valid), 32'(m_sval));
        check(tag, "flash_valid", 32'(flash_valid), 32'(m_fval));
        check(tag, "bank_fault", 32'(bank_fault), 32'(exp_fault()));
        for (int i = 0; i < NS; i++) m_sval[i] = e_spwr[i] ? (m_sval[i] | sram_init[i]) : 1'b0;
        for (int i = 0; i < NF; i++) m_fval[i] = e_fpwr[i] ? (m_fval[i] | flash_init[i]) : 1'b0;
        if (reg_wr) begin
            case (reg_addr)
                12'h140: m_slp  = reg_wdata[7:0];
                12'h144: m_sdis = reg_wdata[7:0];
                12'h148: m_fdis = reg_wdata[1:0];
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        cyc(tag);
        reg_wr = 1'b0;
        cyc(tag);
    endtask

    task automatic rd(input logic [11:0] a, input string tag);
        reg_addr = a;
        cyc(tag);
    endtask

    task automatic access(input longint unsigned a, input string tag);
        acc_valid = 1'b1; acc_addr = 32'(a);
        cyc(tag);
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(12'h140, "R1 reset");
        rd(12'h144, "R1 reset");
        rd(12'h148, "R1 reset");

        // R2 / R3: register map and unused bits
        wr(12'h140, 32'hFFFF_FFA5, "R3 upper bits of sleep mask");
        wr(12'h148, 32'hFFFF_FFFF, "R3 upper bits of flash word");
        wr(12'h144, 32'h0000_003C, "R2 SRAM hard-off write");
        wr(12'h100, 32'hFFFF_FFFF, "R3 write to unused offset");
        rd(12'h140, "R2 read sleep mask");
        rd(12'h144, "R2 read hard-off");
        rd(12'h148, "R2 read flash word");

        // R10: strobes on unpowered banks ignored; R7 on powered ones
        sram_init = 8'hFF; flash_init = 2'b11;
        cyc("R10 strobe on unpowered banks");
        sram_init = 8'h00; flash_init = 2'b00;
        cyc("R7 powered banks become valid");
        wr(12'h148, 32'h0, "R2 flash enable");
        wr(12'h144, 32'h0, "R2 SRAM enable");
        cyc("R8 valid stays clear after power returns");
        sram_init = 8'hFF; flash_init = 2'b11;
        cyc("R7 strobe all");
        sram_init = 8'h00; flash_init = 2'b00;
        cyc("R7 all valid");

        // R5 / R6: address sweep with a bank pattern
        wr(12'h144, 32'h0000_005A, "R2 SRAM pattern");
        wr(12'h148, 32'h0000_0002, "R2 flash pattern");
        cyc("R8 disabled banks lose valid");
        for (int i = 0; i < NS; i++) begin
            access(SB + i * SS, "R5 first byte of SRAM bank");
            access(SB + i * SS + SS - 1, "R5 last byte of SRAM bank");
        end
        for (int j = 0; j < NF; j++) begin
            access(FB + j * FS, "R5 first byte of flash bank");
            access(FB + j * FS + FS - 1, "R5 last byte of flash bank");
        end
        access(SB - 1, "R6 below SRAM base");
        access(SB + NS * SS, "R6 past last SRAM bank");
        access(FB - 1, "R6 below flash base");
        access(FB + NF * FS, "R6 past last flash bank");
        acc_addr = 32'(SB + 3 * SS);
        cyc("R6 no access, no fault");

        // R9 / R4: deep sleep
        wr(12'h144, 32'h0, "R2 SRAM all on");
        wr(12'h148, 32'h0, "R2 flash all on");
        sram_init = 8'hFF; flash_init = 2'b11;
        cyc("R7 refill");
        sram_init = 8'h00; flash_init = 2'b00;
        wr(12'h140, 32'h0000_0033, "R2 sleep mask");
        deep_sleep = 1'b1;
        cyc("R4 sleep entry drops marked banks");
        cyc("R9 unmarked banks keep contents");
        access(SB + 0 * SS + 4, "R6 access to sleep-dropped bank");
        access(FB + 4, "R4 flash unaffected by sleep");
        deep_sleep = 1'b0;
        cyc("R8 wake keeps lost banks invalid");
        cyc("R8 wake keeps lost banks invalid");

        // Randomised phase against the model
        for (int n = 0; n < 400; n++) begin
            int unsigned r;
            r = $urandom;
            reg_wr = (r % 4) == 0;
            case ((r >> 2) % 5)
                0: reg_addr = 12'h140;
                1: reg_addr = 12'h144;
                2: reg_addr = 12'h148;
                3: reg_addr = 12'h14C;
                default: reg_addr = 12'h100;
            endcase
            reg_wdata = $urandom;
            if (((r >> 5) % 16) == 0) deep_sleep = ~deep_sleep;
            sram_init = (((r >> 9) % 4) == 0) ? 8'($urandom) : 8'h00;
            flash_init = (((r >> 11) % 4) == 0) ? 2'($urandom) : 2'b00;
            acc_valid = ((r >> 13) % 2) == 1;
            if (((r >> 14) % 2) == 0)
                acc_addr = 32'(SB - 8 + ($urandom % (NS * SS + 16)));
            else
                acc_addr = 32'(FB - 8 + ($urandom % (NF * FS + 16)));
            cyc("R5 random traffic");
        end
        reg_wr = 1'b0; acc_valid = 1'b0;
        cyc("R4 random tail");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule